// File: doc/BRIEF.md
# JTAG Stream Master

This block drives a JTAG chain by replaying bit streams that were loaded beforehand, without any TAP controller of its own. A host loads a TMS stream, a data-out stream and a transfer length, then issues a start command. The block generates TCK from the system clock through a programmable divider and presents one TMS bit and one TDO bit per TCK period. It samples the returning TDI line into a receive register of the same size. A one-cycle done pulse marks the end of the transfer. The host works out the TAP state walk, instruction codes and data patterns and encodes them in the streams. The block only shifts bits.

The edge that moves the outputs to the next bit and the edge that samples TDI can each be moved within the TCK period. The resting level of every output can be inverted. A separate command issues a reset pulse of programmable length on its own output. Configuration, streams and commands are taken only while the block is idle.

Top module: `jtag_stream_master`

## Requirements
- R1: After reset, tck_o, tms_o, tdo_o and rst_o are 0, busy and done are 0, and rx_data is all zeros.
- R2: A go_shift while idle starts a transfer of L bits, where L = len (len 0 means 128). busy is high for exactly 2·L·(div+1) clocks. TCK makes 2·L edges, one every div+1 clocks, beginning and ending at its resting level. This gives TCK = f_clk / (2·(div+1)).
- R3: TCK period k runs from edge 2k (leading) to edge 2k+1 (trailing). Bit k of the TMS and TDO registers (bit 0 first) is on tms_o and tdo_o at trailing edge 2k+1. tms_o and tdo_o change only in a cycle where TCK changes.
- R4: With cfg_launch_inv = 0 the outputs move to bit k+1 at trailing edge 2k+1, so just before leading edge 2k they hold bit k. With cfg_launch_inv = 1 they move at leading edge 2k+2, so just before leading edge 2k they hold bit k−1. Bit 0 is presented from the start of the transfer.
- R5: With cfg_capture_inv = 0, TDI is sampled at leading edges, and with 1 at trailing edges. Sample j of a transfer goes to rx_data bit j. rx_data is cleared at the start of a transfer, so bits L and above read 0.
- R6: While idle, tck_o, tms_o, tdo_o and rst_o rest at cfg_idle_inv. The leading edge of each TCK period moves TCK away from that level, so with level 0 it is a rising edge.
- R7: done is a one-clock pulse in the cycle where busy falls, after a transfer and after a reset pulse.
- R8: A go_reset while idle (with go_shift low) drives rst_o to the inverse of the resting level for exactly rst_len+1 clocks, with busy high for that time.
- R9: While busy, writes to the TMS, TDO, length and configuration registers are ignored, as are go_shift and go_reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tms_we | input | 1 | Write strobe for the TMS stream register |
| tms_wdata | input | 128 | TMS stream, bit 0 sent first |
| tdo_we | input | 1 | Write strobe for the data-out stream register |
| tdo_wdata | input | 128 | Data-out stream, bit 0 sent first |
| len_we | input | 1 | Write strobe for the length register |
| len_wdata | input | 8 | Transfer length in bits, 0 meaning 128 |
| cfg_we | input | 1 | Write strobe for the configuration fields below |
| cfg_div | input | 7 | TCK half period minus one, in clocks |
| cfg_launch_inv | input | 1 | Move outputs on leading instead of trailing edges |
| cfg_capture_inv | input | 1 | Sample TDI on trailing instead of leading edges |
| cfg_idle_inv | input | 1 | Resting level of all outputs |
| cfg_rst_len | input | 8 | Reset pulse length minus one, in clocks |
| go_shift | input | 1 | Start a stream transfer |
| go_reset | input | 1 | Start a reset pulse |
| tdi_i | input | 1 | Serial data returned from the chain |
| tck_o | output | 1 | Test clock |
| tms_o | output | 1 | Test mode select |
| tdo_o | output | 1 | Serial data to the chain |
| rst_o | output | 1 | Reset pulse to the chain |
| rx_data | output | 128 | Captured TDI stream, bit j is sample j |
| busy | output | 1 | Transfer or reset pulse in progress |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
The assertions assume that the host holds its write strobes and start commands to single, well-formed cycles, and that a start is not combined with a conflicting write of the same register. They also assume that TDI is only meaningful around the sampling edges. The bench keeps to this. It drives each strobe for exactly one clock on a falling edge. It changes TDI only after it has seen the capture edge that consumed the previous bit. It issues writes or starts while busy only in a dedicated run, which then shows through a second unloaded transfer that those writes were ignored.

// File: rtl/jtag_stream_master.sv
module jtag_stream_master #(
  parameter int N  = 128,
  parameter int DW = 7,
  parameter int RW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tms_we,
  input  logic [N-1:0]              tms_wdata,
  input  logic                      tdo_we,
  input  logic [N-1:0]              tdo_wdata,
  input  logic                      len_we,
  input  logic [$clog2(N+1)-1:0]    len_wdata,
  input  logic                      cfg_we,
  input  logic [DW-1:0]             cfg_div,
  input  logic                      cfg_launch_inv,
  input  logic                      cfg_capture_inv,
  input  logic                      cfg_idle_inv,
  input  logic [RW-1:0]             cfg_rst_len,
  input  logic                      go_shift,
  input  logic                      go_reset,
  input  logic                      tdi_i,
  output logic                      tck_o,
  output logic                      tms_o,
  output logic                      tdo_o,
  output logic                      rst_o,
  output logic [N-1:0]              rx_data,
  output logic                      busy,
  output logic                      done
);
  localparam int LW = $clog2(N+1);
  localparam int IW = $clog2(N);
  localparam int EW = $clog2(2*N);

  typedef enum logic [1:0] {M_IDLE, M_SHIFT, M_RSTP} mode_t;

  mode_t          mode;
  logic [N-1:0]   tms_q, tdo_q, rx_q;
  logic [LW-1:0]  len_q;
  logic [DW-1:0]  div_q, divcnt;
  logic [RW-1:0]  rlen_q, rcnt;
  logic           li_q, ci_q, ii_q;
  logic [EW-1:0]  ecnt;
  logic [IW-1:0]  idx, cidx;
  logic           ph, done_q;

  logic [LW-1:0]  nb;
  logic [LW:0]    two_nb;
  logic [EW-1:0]  last_e;
  logic           idle, shifting, tick, lead, cap_ev, launch_ev;

  assign idle     = (mode == M_IDLE);
  assign shifting = (mode == M_SHIFT);
  assign nb       = (len_q == '0) ? LW'(N) : len_q;
  assign two_nb   = {nb, 1'b0};
  assign last_e   = EW'(two_nb - (LW+1)'(1));
  assign tick     = (divcnt == div_q);
  assign lead     = ~ecnt[0];
  assign cap_ev   = shifting && tick && (lead ^ ci_q);
  assign launch_ev = shifting && tick &&
                     (li_q ? (lead && ecnt != '0) : (!lead && ecnt != last_e));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tms_q  <= '0;
      tdo_q  <= '0;
      len_q  <= '0;
      div_q  <= '0;
      rlen_q <= '0;
      li_q   <= 1'b0;
      ci_q   <= 1'b0;
      ii_q   <= 1'b0;
    end else if (idle) begin
      if (tms_we) tms_q <= tms_wdata;
      if (tdo_we) tdo_q <= tdo_wdata;
      if (len_we) len_q <= len_wdata;
      if (cfg_we) begin
        div_q  <= cfg_div;
        li_q   <= cfg_launch_inv;
        ci_q   <= cfg_capture_inv;
        ii_q   <= cfg_idle_inv;
        rlen_q <= cfg_rst_len;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= M_IDLE;
      divcnt <= '0;
      ecnt   <= '0;
      idx    <= '0;
      cidx   <= '0;
      ph     <= 1'b0;
      rcnt   <= '0;
      rx_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (mode)
        M_IDLE: begin
          if (go_shift) begin
            mode   <= M_SHIFT;
            divcnt <= '0;
            ecnt   <= '0;
            idx    <= '0;
            cidx   <= '0;
            ph     <= 1'b0;
            rx_q   <= '0;
          end else if (go_reset) begin
            mode <= M_RSTP;
            rcnt <= rlen_q;
          end
        end
        M_SHIFT: begin
          if (tick) begin
            divcnt <= '0;
            ph     <= ~ph;
            ecnt   <= ecnt + 1'b1;
            if (cap_ev) begin
              rx_q[cidx] <= tdi_i;
              cidx       <= cidx + 1'b1;
            end
            if (launch_ev) idx <= idx + 1'b1;
            if (ecnt == last_e) begin
              mode   <= M_IDLE;
              done_q <= 1'b1;
            end
          end else begin
            divcnt <= divcnt + 1'b1;
          end
        end
        M_RSTP: begin
          if (rcnt == '0) begin
            mode   <= M_IDLE;
            done_q <= 1'b1;
          end else begin
            rcnt <= rcnt - 1'b1;
          end
        end
        default: mode <= M_IDLE;
      endcase
    end
  end

  assign tck_o   = ii_q ^ (shifting & ph);
  assign tms_o   = shifting ? tms_q[idx] : ii_q;
  assign tdo_o   = shifting ? tdo_q[idx] : ii_q;
  assign rst_o   = ii_q ^ (mode == M_RSTP);
  assign rx_data = rx_q;
  assign busy    = !idle;
  assign done    = done_q;
endmodule

// File: rtl/jtag_stream_master_chk.sv
module jtag_stream_master_chk #(
  parameter int N = 128
) (
  input logic         clk,
  input logic         rst_n,
  input logic         go_shift,
  input logic         tms_we,
  input logic         busy,
  input logic         done,
  input logic         tck_o,
  input logic         tms_o,
  input logic         tdo_o,
  input logic         rst_o,
  input logic         idle_lvl,
  input logic [N-1:0] tms_q
);
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (go_shift && !busy) |=> busy);

  p_hold_between_edges_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $stable(tck_o)) |-> ($stable(tms_o) && $stable(tdo_o)));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(busy));

  p_pulse_inside_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_o != idle_lvl) |-> busy);

  p_locked_while_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tms_we) |=> $stable(tms_q));

  p_rest_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> (tck_o == idle_lvl && rst_o == idle_lvl));
endmodule

bind jtag_stream_master jtag_stream_master_chk #(.N(N)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .go_shift (go_shift),
  .tms_we   (tms_we),
  .busy     (busy),
  .done     (done),
  .tck_o    (tck_o),
  .tms_o    (tms_o),
  .tdo_o    (tdo_o),
  .rst_o    (rst_o),
  .idle_lvl (ii_q),
  .tms_q    (tms_q)
);

// File: tb/sim_jtag_stream_master.sv
`timescale 1ns/1ps
module sim_jtag_stream_master;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         tms_we, tdo_we, len_we, cfg_we;
  logic [127:0] tms_wdata, tdo_wdata;
  logic [7:0]   len_wdata;
  logic [6:0]   cfg_div;
  logic         cfg_launch_inv, cfg_capture_inv, cfg_idle_inv;
  logic [7:0]   cfg_rst_len;
  logic         go_shift, go_reset, tdi_i;
  logic         tck_o, tms_o, tdo_o, rst_o, busy, done;
  logic [127:0] rx_data;

  int n_run = 0;
  int n_fail = 0;

  logic [127:0] g_tms, g_tdo, g_tdi;
  int           g_nb, g_div;
  bit           g_li, g_ci, g_ii;

  always #2.5 clk = ~clk;

  jtag_stream_master u0 (
    .clk(clk), .rst_n(rst_n),
    .tms_we(tms_we), .tms_wdata(tms_wdata),
    .tdo_we(tdo_we), .tdo_wdata(tdo_wdata),
    .len_we(len_we), .len_wdata(len_wdata),
    .cfg_we(cfg_we), .cfg_div(cfg_div),
    .cfg_launch_inv(cfg_launch_inv), .cfg_capture_inv(cfg_capture_inv),
    .cfg_idle_inv(cfg_idle_inv), .cfg_rst_len(cfg_rst_len),
    .go_shift(go_shift), .go_reset(go_reset), .tdi_i(tdi_i),
    .tck_o(tck_o), .tms_o(tms_o), .tdo_o(tdo_o), .rst_o(rst_o),
    .rx_data(rx_data), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] pat(input int unsigned seed);
    logic [127:0] r;
    int unsigned x;
    x = seed * 32'd2654435761 + 32'd7;
    for (int i = 0; i < 4; i++) begin
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      r[i*32 +: 32] = x;
    end
    return r;
  endfunction

  task automatic write_cfg(input int dv, input bit li, input bit ci, input bit ii,
                           input int rl);
    @(negedge clk);
    cfg_we = 1'b1; cfg_div = 7'(dv); cfg_launch_inv = li;
    cfg_capture_inv = ci; cfg_idle_inv = ii; cfg_rst_len = 8'(rl);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run(input int dv, input int ln, input bit li, input bit ci,
                     input bit ii, input bit load, input bit poke, input int seed);
    int edges = 0, bcyc = 0, dcnt = 0, serr = 0, terr = 0, capidx = 0, e, k, eb;
    bit lead, ended = 0;
    logic ptck, ptms, ptdo;
    logic [127:0] exp_rx;
    if (load) begin
      g_tms = pat(seed); g_tdo = pat(seed + 11);
      g_nb = (ln == 0) ? 128 : ln; g_div = dv; g_li = li; g_ci = ci; g_ii = ii;
      @(negedge clk);
      tms_we = 1'b1; tms_wdata = g_tms;
      tdo_we = 1'b1; tdo_wdata = g_tdo;
      len_we = 1'b1; len_wdata = 8'(ln);
      @(negedge clk);
      tms_we = 1'b0; tdo_we = 1'b0; len_we = 1'b0;
      write_cfg(dv, li, ci, ii, 2);
    end
    g_tdi = pat(seed + 23);
    tdi_i = g_tdi[0];
    @(negedge clk);
    go_shift = 1'b1;
    @(negedge clk);
    go_shift = 1'b0;
    ptck = g_ii; ptms = tms_o; ptdo = tdo_o;
    for (int c = 0; c < 5000; c++) begin
      if (poke && c == 1) begin
        tms_we = 1'b1; tms_wdata = ~g_tms;
        tdo_we = 1'b1; tdo_wdata = ~g_tdo;
        len_we = 1'b1; len_wdata = 8'd9;
        cfg_we = 1'b1; cfg_div = 7'd5; cfg_launch_inv = ~g_li;
        cfg_capture_inv = ~g_ci; cfg_idle_inv = ~g_ii;
        go_shift = 1'b1; go_reset = 1'b1;
      end
      if (poke && c == 2) begin
        tms_we = 1'b0; tdo_we = 1'b0; len_we = 1'b0; cfg_we = 1'b0;
        go_shift = 1'b0; go_reset = 1'b0;
      end
      if (busy) bcyc++;
      if (done) dcnt++;
      if (tck_o !== ptck) begin
        e = edges; lead = (e % 2 == 0); k = e / 2;
        if (tck_o !== (lead ? ~g_ii : g_ii)) terr++;
        if (c != (e + 1) * (g_div + 1)) terr++;
        if (lead && k >= 1) begin
          eb = g_li ? k - 1 : k;
          if (ptms !== g_tms[eb] || ptdo !== g_tdo[eb]) serr++;
        end else if (!lead) begin
          if (ptms !== g_tms[k] || ptdo !== g_tdo[k]) serr++;
        end
        if (lead ^ g_ci) begin
          capidx++;
          if (capidx < 128) tdi_i = g_tdi[capidx];
        end
        edges++;
      end
      ptck = tck_o; ptms = tms_o; ptdo = tdo_o;
      if (!busy) begin
        ended = 1;
        break;
      end
      @(negedge clk);
    end
    for (int i = 0; i < 128; i++) exp_rx[i] = (i < g_nb) ? g_tdi[i] : 1'b0;
    chk(ended && edges == 2 * g_nb, "R2 tck edge count", 128'(edges), 128'(2 * g_nb));
    chk(bcyc == 2 * g_nb * (g_div + 1), "R2 busy length", 128'(bcyc),
        128'(2 * g_nb * (g_div + 1)));
    chk(terr == 0, "R2/R6 tck spacing and level", 128'(terr), 128'd0);
    chk(serr == 0, "R3/R4 tms/tdo stream at launch edges", 128'(serr), 128'd0);
    chk(rx_data === exp_rx, "R5 captured tdi", rx_data, exp_rx);
    chk(dcnt == 1, "R7 done pulse count", 128'(dcnt), 128'd1);
    chk(tck_o === g_ii && tms_o === g_ii && tdo_o === g_ii && rst_o === g_ii,
        "R6 resting levels", {tck_o, tms_o, tdo_o, rst_o}, {4{g_ii}});
  endtask

  task automatic rpulse(input int rl, input bit ii);
    int act = 0, bcyc = 0, dcnt = 0;
    g_ii = ii;
    write_cfg(g_div, g_li, g_ci, ii, rl);
    @(negedge clk);
    go_reset = 1'b1;
    @(negedge clk);
    go_reset = 1'b0;
    for (int c = 0; c < 600; c++) begin
      if (rst_o !== ii) act++;
      if (busy) bcyc++;
      if (done) dcnt++;
      if (!busy && c > 0) break;
      if (!busy && c == 0) break;
      @(negedge clk);
    end
    chk(act == rl + 1, "R8 reset pulse length", 128'(act), 128'(rl + 1));
    chk(bcyc == rl + 1, "R8 busy during reset pulse", 128'(bcyc), 128'(rl + 1));
    chk(dcnt == 1, "R7 done after reset pulse", 128'(dcnt), 128'd1);
    chk(tck_o === ii, "R8 tck untouched by reset pulse", 128'(tck_o), 128'(ii));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int seed = 1;
    int divs[3] = '{0, 1, 3};
    int lens[4] = '{1, 2, 7, 0};
    rst_n = 1'b0;
    tms_we = 0; tdo_we = 0; len_we = 0; cfg_we = 0;
    tms_wdata = '0; tdo_wdata = '0; len_wdata = '0;
    cfg_div = '0; cfg_launch_inv = 0; cfg_capture_inv = 0; cfg_idle_inv = 0;
    cfg_rst_len = '0; go_shift = 0; go_reset = 0; tdi_i = 0;
    g_div = 0; g_li = 0; g_ci = 0; g_ii = 0; g_nb = 128;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tck_o === 0 && tms_o === 0 && tdo_o === 0 && rst_o === 0,
        "R1 outputs after reset", {tck_o, tms_o, tdo_o, rst_o}, 128'd0);
    chk(busy === 0 && done === 0, "R1 busy/done after reset", {busy, done}, 128'd0);
    chk(rx_data === '0, "R1 rx_data after reset", rx_data, 128'd0);

    for (int d = 0; d < 3; d++)
      for (int l = 0; l < 4; l++)
        for (int f = 0; f < 8; f++) begin
          run(divs[d], lens[l], f[0], f[1], f[2], 1'b1, 1'b0, seed);
          seed++;
        end

    // R9: writes and starts while busy must be ignored
    run(1, 4, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 500);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(busy === 0 && rst_o === g_ii, "R9 go during busy ignored",
          {busy, rst_o}, {1'b0, g_ii});
    end
    run(1, 4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 501);

    rpulse(0, 1'b0);
    rpulse(3, 1'b0);
    rpulse(5, 1'b1);
    rpulse(17, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule